// File: doc/BRIEF.md
# Eight-Lane Prime-Field-31 Inverter by Exponentiation

This block computes the multiplicative inverse of eight elements of the prime field with 31 elements. All eight lanes work at the same time. No lookup table and no extended Euclid are used. Each lane raises its operand to the power 29, which is q−2 for q = 31. It does this with a fixed chain of four passes: x³, then x⁷, then x¹⁴, then x²⁹. Every pass reduces its result back into the range 0..30 before the next pass begins, so no intermediate value grows past ten bits.

A controller steps through the four passes over one shared, lane-parallel square-and-multiply unit, one pass per clock. The unit forms p·r·r mod 31 in each lane. A start strobe loads all eight operands. Four cycles later a single-cycle done strobe presents the eight inverses and a per-lane flag that marks operands congruent to zero. The results and flags then hold steady until the next done strobe. A new start is taken while the block is idle or during the done cycle, so operations can run back to back.

Top module: `f31_vec_inv`

## Requirements
- R1: While reset is held and after it is released, with no start applied, done_o, busy_o, every bit of inv_o and every bit of zero_o are 0.
- R2: A start_i sampled high at a rising edge while busy_o is low is accepted. It captures all lanes of x_i, and busy_o is then high for exactly the next four cycles.
- R3: If start is accepted at edge n, done_o is high from edge n+4 to edge n+5 and low otherwise. It is never high for two cycles in a row.
- R4: For a lane operand x in 1..30, the lane result equals x^29 mod 31, so that x times the result is congruent to 1 mod 31.
- R5: A lane operand of 0 gives a result of 0 and sets that lane's bit of zero_o. A nonzero operand clears it.
- R6: The 5-bit lane code 31 is taken as the residue 0: its result is 0 and its zero_o bit is set.
- R7: A start_i that arrives while busy_o is high is ignored. The done timing and the results belong to the operation already in progress.
- R8: inv_o and zero_o change only at the edge that raises done_o. Between done pulses they hold their values even when x_i changes.
- R9: Lane i uses bits [5i+4:5i] of x_i, inv_o and bit i of zero_o, with lane 0 at the least significant bits. The lanes do not interact.
- R10: A start applied during the done cycle is accepted, and its result appears four cycles later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request to load x_i and begin an inversion |
| x_i | input | 40 | Eight 5-bit lane operands, lane 0 in the low bits |
| inv_o | output | 40 | Eight 5-bit lane inverses, lane 0 in the low bits |
| zero_o | output | 8 | Per-lane flag: operand congruent to zero |
| busy_o | output | 1 | High while the four passes run |
| done_o | output | 1 | One-cycle strobe marking fresh results |

## Verification
The bench runs 31 operations. In each one, lane i carries the value (k+3i) mod 31. Over the run, every lane therefore sees every nonzero residue, plus zero. This shows whether the whole exponent chain and the reduction are correct in each lane, and whether any lane is miswired or shares state with another. A vector of code-31 operands mixed with ordinary values separates the residue-0 handling from plain zero. A second start issued mid-operation shows whether the busy guard works. Two back-to-back starts show whether the done-cycle restart is accepted. A run that changes x_i while the block is idle shows whether the outputs track the input or the last result.

// File: rtl/f31_pkg.sv
package f31_pkg;
    localparam int EW = 5;
    localparam int PW = 2 * EW;
    localparam logic [EW-1:0] MODQ = 5'd31;

    typedef logic [EW-1:0] elem_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_P1,
        ST_P2,
        ST_P3,
        ST_P4,
        ST_DONE
    } step_e;

    // Reduce a 10-bit value mod 31 using 32 == 1 (mod 31).
    function automatic elem_t fold_mod(input logic [PW-1:0] v);
        logic [EW:0] s;
        logic [EW:0] t;
        s = {1'b0, v[PW-1:EW]} + {1'b0, v[EW-1:0]};
        t = {{EW{1'b0}}, s[EW]} + {1'b0, s[EW-1:0]};
        if (t >= {1'b0, MODQ}) begin
            t = t - {1'b0, MODQ};
        end
        return t[EW-1:0];
    endfunction
endpackage

// File: rtl/f31_lane_mr.sv
module f31_lane_mr
    import f31_pkg::*;
(
    input  logic [EW-1:0] p_i,
    input  logic [EW-1:0] r_i,
    output logic [EW-1:0] m_o
);
    logic [PW-1:0] sq_w;
    logic [EW-1:0] sqr_w;
    logic [PW-1:0] pr_w;

    always_comb begin
        sq_w  = PW'(r_i) * PW'(r_i);
        sqr_w = fold_mod(sq_w);
        pr_w  = PW'(p_i) * PW'(sqr_w);
        m_o   = fold_mod(pr_w);
    end
endmodule

// File: rtl/f31_inv_ctrl.sv
module f31_inv_ctrl
    import f31_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic accept_o,
    output logic first_o,
    output logic unit_o,
    output logic last_o,
    output logic busy_o,
    output logic done_o
);
    typedef struct packed {
        step_e st;
    } ctrl_t;

    ctrl_t c_d, c_q;

    always_comb begin
        c_d      = c_q;
        busy_o   = (c_q.st == ST_P1) || (c_q.st == ST_P2) ||
                   (c_q.st == ST_P3) || (c_q.st == ST_P4);
        done_o   = (c_q.st == ST_DONE);
        accept_o = start_i && !busy_o;
        first_o  = (c_q.st == ST_P1);
        unit_o   = (c_q.st == ST_P3);
        last_o   = (c_q.st == ST_P4);
        case (c_q.st)
            ST_IDLE, ST_DONE: c_d.st = accept_o ? ST_P1 : ST_IDLE;
            ST_P1:            c_d.st = ST_P2;
            ST_P2:            c_d.st = ST_P3;
            ST_P3:            c_d.st = ST_P4;
            ST_P4:            c_d.st = ST_DONE;
            default:          c_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_q.st <= ST_IDLE;
        end else begin
            c_q <= c_d;
        end
    end
endmodule

// File: rtl/f31_vec_inv.sv
module f31_vec_inv
    import f31_pkg::*;
#(
    parameter int LANES = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic [LANES*EW-1:0] x_i,
    output logic [LANES*EW-1:0] inv_o,
    output logic [LANES-1:0]    zero_o,
    output logic                busy_o,
    output logic                done_o
);
    localparam int VW = LANES * EW;

    typedef struct packed {
        logic [LANES-1:0][EW-1:0] x;
        logic [LANES-1:0][EW-1:0] y;
        logic [LANES-1:0][EW-1:0] res;
        logic [LANES-1:0]         zf;
    } dp_t;

    dp_t d_d, d_q;

    logic accept_w, first_w, unit_w, last_w;
    logic [LANES-1:0][EW-1:0] p_w, r_w, m_w;

    f31_inv_ctrl ctrl_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_i),
        .accept_o (accept_w),
        .first_o  (first_w),
        .unit_o   (unit_w),
        .last_o   (last_w),
        .busy_o   (busy_o),
        .done_o   (done_o)
    );

    // Pass 1: x*x*x, pass 2: x*y*y, pass 3: 1*y*y, pass 4: x*y*y.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign p_w[g] = unit_w ? EW'(1) : d_q.x[g];
        assign r_w[g] = first_w ? d_q.x[g] : d_q.y[g];
        f31_lane_mr mr_i (
            .p_i (p_w[g]),
            .r_i (r_w[g]),
            .m_o (m_w[g])
        );
    end

    always_comb begin
        d_d = d_q;
        if (accept_w) begin
            for (int i = 0; i < LANES; i++) begin
                d_d.x[i] = (x_i[i*EW +: EW] == MODQ) ? '0 : x_i[i*EW +: EW];
            end
        end
        if (busy_o) begin
            d_d.y = m_w;
        end
        if (last_w) begin
            d_d.res = m_w;
            for (int i = 0; i < LANES; i++) begin
                d_d.zf[i] = (d_q.x[i] == '0);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            d_q <= '0;
        end else begin
            d_q <= d_d;
        end
    end

    assign inv_o  = VW'(d_q.res);
    assign zero_o = d_q.zf;
endmodule

// File: rtl/f31_vec_inv_chk.sv
module f31_vec_inv_chk
    import f31_pkg::*;
#(
    parameter int LANES = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                start_i,
    input logic [LANES*EW-1:0] x_i,
    input logic [LANES*EW-1:0] inv_o,
    input logic [LANES-1:0]    zero_o,
    input logic                busy_o,
    input logic                done_o
);
    logic [LANES-1:0][EW-1:0] cap_q;
    logic [2:0]               age_q;
    logic                     live_q;
    logic                     good_w;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_q  <= '0;
            age_q  <= '0;
            live_q <= 1'b0;
        end else if (start_i && !busy_o) begin
            for (int i = 0; i < LANES; i++) begin
                cap_q[i] <= (x_i[i*EW +: EW] == 5'd31) ? '0 : x_i[i*EW +: EW];
            end
            age_q  <= 3'd1;
            live_q <= 1'b1;
        end else if (live_q) begin
            age_q  <= age_q + 3'd1;
            live_q <= (age_q < 3'd4);
        end
    end

    always_comb begin
        good_w = 1'b1;
        for (int i = 0; i < LANES; i++) begin
            if (cap_q[i] == '0) begin
                if (inv_o[i*EW +: EW] != '0 || !zero_o[i]) good_w = 1'b0;
            end else begin
                if ((int'(cap_q[i]) * int'(inv_o[i*EW +: EW])) % 31 != 1 || zero_o[i])
                    good_w = 1'b0;
            end
        end
    end

    // R2
    accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> busy_o);

    // R3
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R3
    done_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (live_q && age_q == 3'd4) || (!live_q && age_q == 3'd5));

    // R4
    inverse_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> good_w);

    // R8
    hold_inv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable(inv_o));

    // R8
    hold_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable(zero_o));
endmodule

bind f31_vec_inv f31_vec_inv_chk #(.LANES(LANES)) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .x_i     (x_i),
    .inv_o   (inv_o),
    .zero_o  (zero_o),
    .busy_o  (busy_o),
    .done_o  (done_o)
);

// File: tb/f31_vec_inv_tb_top.sv
module f31_vec_inv_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int LANES = 8;
    localparam int EW = 5;
    localparam int VW = LANES * EW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic [VW-1:0] x_i = '0;
    logic [VW-1:0] inv_o;
    logic [LANES-1:0] zero_o;
    logic          busy_o, done_o;

    int checks = 0;
    int errors = 0;
    bit ended = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    f31_vec_inv #(.LANES(LANES)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .x_i(x_i),
        .inv_o(inv_o), .zero_o(zero_o), .busy_o(busy_o), .done_o(done_o)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int inv31(input int v);
        int r = 0;
        for (int c = 1; c < 31; c++) if ((v * c) % 31 == 1) r = c;
        return r;
    endfunction

    function automatic logic [VW-1:0] exp_inv(input logic [VW-1:0] xv);
        logic [VW-1:0] e = '0;
        for (int i = 0; i < LANES; i++) begin
            int v = int'(xv[i*EW +: EW]) % 31;
            e[i*EW +: EW] = EW'(inv31(v));
        end
        return e;
    endfunction

    function automatic logic [LANES-1:0] exp_zero(input logic [VW-1:0] xv);
        logic [LANES-1:0] z;
        for (int i = 0; i < LANES; i++) z[i] = (int'(xv[i*EW +: EW]) % 31 == 0);
        return z;
    endfunction

    // Starts at a negedge; returns at the negedge inside the done cycle.
    task automatic run_op(input logic [VW-1:0] xv, input string req);
        x_i = xv;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk(busy_o === 1'b1, "R2 busy after accept", 64'(busy_o), 64'd1);
        repeat (3) @(negedge clk);
        chk(done_o === 1'b0 && busy_o === 1'b1, "R3 no early done", 64'(done_o), 64'd0);
        @(negedge clk);
        chk(done_o === 1'b1 && busy_o === 1'b0, "R3 done at fourth edge", 64'(done_o), 64'd1);
        chk(inv_o === exp_inv(xv), req, 64'(inv_o), 64'(exp_inv(xv)));
        chk(zero_o === exp_zero(xv), "R5 zero flags", 64'(zero_o), 64'(exp_zero(xv)));
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(done_o === 0 && busy_o === 0 && inv_o === '0 && zero_o === '0,
            "R1 reset state", {inv_o[23:0], zero_o, 6'b0, busy_o, done_o}, 64'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(done_o === 0 && busy_o === 0 && inv_o === '0,
            "R1 idle after reset", 64'(inv_o), 64'd0);
    endtask

    task automatic t_sweep();
        // Lane i gets (k+3i) mod 31: every lane sees all residues. R4 R9 R10
        for (int k = 0; k < 31; k++) begin
            logic [VW-1:0] xv;
            for (int i = 0; i < LANES; i++) xv[i*EW +: EW] = EW'((k + 3*i) % 31);
            run_op(xv, "R4 R9 sweep inverse");
        end
        @(negedge clk);
    endtask

    task automatic t_code31();
        logic [VW-1:0] xv = {5'd31, 5'd1, 5'd31, 5'd0, 5'd30, 5'd31, 5'd2, 5'd31};
        run_op(xv, "R6 code 31 as zero");
        @(negedge clk);
    endtask

    task automatic t_busy_ignore();
        logic [VW-1:0] a = {5'd3, 5'd5, 5'd7, 5'd11, 5'd13, 5'd17, 5'd19, 5'd23};
        logic [VW-1:0] b = {8{5'd2}};
        x_i = a;
        start_i = 1'b1;
        @(negedge clk);
        x_i = b;
        @(negedge clk);
        start_i = 1'b0;
        repeat (2) @(negedge clk);
        chk(done_o === 1'b0, "R7 no done before fourth edge", 64'(done_o), 64'd0);
        @(negedge clk);
        chk(done_o === 1'b1, "R7 done timing kept", 64'(done_o), 64'd1);
        chk(inv_o === exp_inv(a), "R7 first operands used", 64'(inv_o), 64'(exp_inv(a)));
        @(negedge clk);
        chk(done_o === 1'b0 && busy_o === 1'b0, "R7 no second run", 64'(busy_o), 64'd0);
    endtask

    task automatic t_hold();
        logic [VW-1:0] a = {5'd9, 5'd8, 5'd0, 5'd6, 5'd4, 5'd29, 5'd16, 5'd1};
        logic [VW-1:0] held;
        run_op(a, "R4 hold setup");
        held = inv_o;
        for (int j = 0; j < 6; j++) begin
            x_i = VW'(j * 40'h1234567);
            @(negedge clk);
        end
        chk(inv_o === held && done_o === 1'b0, "R8 outputs hold", 64'(inv_o), 64'(held));
        chk(zero_o === exp_zero(a), "R8 zero flags hold", 64'(zero_o), 64'(exp_zero(a)));
    endtask

    task automatic t_back2back();
        logic [VW-1:0] a = {8{5'd12}};
        logic [VW-1:0] b = {5'd1, 5'd2, 5'd3, 5'd4, 5'd5, 5'd6, 5'd7, 5'd8};
        run_op(a, "R10 first op");
        run_op(b, "R10 restart in done cycle");
        @(negedge clk);
    endtask

    initial begin
        t_reset();
        t_sweep();
        t_code31();
        t_busy_ignore();
        t_hold();
        t_back2back();
        if (!ended) begin
            ended = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!ended) begin
            ended = 1;
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule